// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives 8-bit characters from an asynchronous serial line. A strobe from a baud divider ticks 16 times per bit period. On each tick the receiver looks at the line and finds the falling edge of a start bit. It confirms the start bit half a bit later. It then samples every later bit at its centre and assembles the character in a shift register.

When the final stop bit has been sampled, the character moves into a receive buffer. At that same moment the block judges the frame for three faults: a missing stop level, a parity mismatch, and a buffer that the consumer has not yet emptied. Each fault sets a sticky flag, and a combined flag reports that any of them is set. A character that arrives without overrun raises a one-cycle interrupt request.

The consumer reads the character and then pulses the low-byte read strobe. That pulse empties the buffer and drops the framing and parity flags. The overrun flag clears only when the receiver is shut down.

Top module: `uart_rx_core`

## Requirements
- R1: After synchronous reset, `rx_data` is 0 and `rx_full`, `err_ovr`, `err_frm`, `err_par`, `err_any` and `rx_irq` are all 0.
- R2: A start bit counts only if the line is still low at the 8th `os_tick` after the tick that saw the high-to-low change. A low pulse shorter than that returns the receiver to idle, and nothing is transferred.
- R3: The 8 data bits are sampled every 16 ticks and shifted in least significant bit first. At the transfer the character appears on `rx_data` and `rx_full` goes to 1. `rx_data` changes at no other time. Without overrun, `rx_irq` pulses high for exactly one clock.
- R4: When `par_en`=1, a parity bit follows data bit 7. `par_odd`=1 selects odd parity and `par_odd`=0 selects even parity. `err_par` is set at the transfer when the number of ones across the 8 data bits and the parity bit has the wrong oddness.
- R5: When `par_en`=0, no parity bit is expected, the first stop bit follows data bit 7, and `err_par` is never set.
- R6: `err_frm` is set at the transfer if any configured stop-bit sample is low. The character is still stored in the buffer.
- R7: A transfer while `rx_full`=1, with no `rd_lo` in the same cycle, sets `err_ovr`. The new character still overwrites `rx_data`, and `rx_irq` is not raised.
- R8: A `rd_lo` pulse clears `rx_full`, `err_frm` and `err_par` on the next clock. It leaves `err_ovr` unchanged.
- R9: `err_any` is 1 whenever any of `err_ovr`, `err_frm` or `err_par` is 1. It falls only when all three are 0.
- R10: The receiver runs only while `rx_en`=1 and `mode_sel`=3'b101. With `mode_sel`=3'b000 or `rx_en`=0, all error flags and `rx_full` clear on the next clock. With any other mode code, incoming frames are ignored and state is held.
- R11: With `stop2`=1, two stop bits are sampled and the transfer occurs at the second one. A low level in either stop bit counts as a framing error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| os_tick | input | 1 | One-clock strobe at 16 times the bit rate |
| rx_en | input | 1 | Receive enable |
| mode_sel | input | 3 | Mode code: 3'b101 runs the receiver, 3'b000 shuts it down |
| par_en | input | 1 | A parity bit is expected |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop2 | input | 1 | 1 selects two stop bits, 0 selects one |
| rd_lo | input | 1 | Low-byte read strobe from the consumer |
| rx_data | output | 8 | Receive buffer |
| rx_full | output | 1 | Buffer holds an unread character |
| err_ovr | output | 1 | Sticky overrun flag |
| err_frm | output | 1 | Sticky framing flag |
| err_par | output | 1 | Sticky parity flag |
| err_any | output | 1 | Combined error flag |
| rx_irq | output | 1 | One-clock receive-complete request |

## Verification
Directed frames use known characters under even parity, odd parity and no parity, with one or two stop bits. They show whether bits land LSB first and whether the parity bit and stop bits are taken from the right positions. A corrupted first or second stop bit shows whether the second stop sample is really taken. Back-to-back frames without a read separate the overrun path, where the buffer is overwritten and no request is raised, from the normal path. A later read shows that the overrun flag outlives the read. A short start glitch, an unsupported mode code, a disabled receiver and the all-zero mode each check that frames are rejected or that flags are cleared. A seeded random run then mixes characters, configurations, corrupt parity or stop bits, and skipped reads against a bench model of buffer and flag state.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W   = 8;
    localparam int OS_RATE  = 16;
    localparam int MID_TICK = 8;
    localparam int CNT_W    = $clog2(OS_RATE);
    localparam int IDX_W    = $clog2(DATA_W);

    localparam logic [2:0] MODE_OFF   = 3'b000;
    localparam logic [2:0] MODE_ASYNC = 3'b101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic par_en;
        logic par_odd;
        logic two_stop;
    } rx_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              frm_bad;
        logic              par_bad;
    } rx_frame_t;

    typedef struct packed {
        logic ovr;
        logic frm;
        logic par;
    } rx_err_t;

    // True when data plus parity bit carry the wrong oddness of ones
    function automatic logic parity_mismatch(input logic [DATA_W-1:0] data,
                                             input logic pbit,
                                             input logic odd);
        return (^{data, pbit}) != odd;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b1;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
    import uart_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  logic      os_tick,
    input  logic      line,
    input  rx_cfg_t   cfg,
    output logic      xfer,
    output rx_frame_t frame
);
    localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(MID_TICK - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OS_RATE - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  tick_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              line_prev;
    logic              par_bit;
    logic              stop_bad;
    rx_cfg_t           cfg_q;
    logic              at_mid;
    logic              at_bit;

    assign at_mid = os_tick && (tick_cnt == MID_LAST);
    assign at_bit = os_tick && (tick_cnt == BIT_LAST);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            state     <= ST_IDLE;
            tick_cnt  <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            line_prev <= 1'b1;
            par_bit   <= 1'b0;
            stop_bad  <= 1'b0;
            cfg_q     <= '0;
            xfer      <= 1'b0;
            frame     <= '0;
        end else begin
            xfer <= 1'b0;
            if (os_tick) begin
                line_prev <= line;
                unique case (state)
                    ST_IDLE: begin
                        if (line_prev && !line) begin
                            state    <= ST_START;
                            tick_cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (at_mid) begin
                            tick_cnt <= '0;
                            bit_idx  <= '0;
                            cfg_q    <= cfg;
                            state    <= line ? ST_IDLE : ST_DATA;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        tick_cnt <= tick_cnt + 1'b1;
                        if (at_bit) begin
                            shreg <= {line, shreg[DATA_W-1:1]};
                            if (bit_idx == IDX_LAST)
                                state <= cfg_q.par_en ? ST_PAR : ST_STOP1;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        tick_cnt <= tick_cnt + 1'b1;
                        if (at_bit) begin
                            par_bit <= line;
                            state   <= ST_STOP1;
                        end
                    end
                    ST_STOP1: begin
                        tick_cnt <= tick_cnt + 1'b1;
                        if (at_bit) begin
                            if (cfg_q.two_stop) begin
                                stop_bad <= !line;
                                state    <= ST_STOP2;
                            end else begin
                                xfer          <= 1'b1;
                                frame.data    <= shreg;
                                frame.frm_bad <= !line;
                                frame.par_bad <= cfg_q.par_en &&
                                    parity_mismatch(shreg, par_bit, cfg_q.par_odd);
                                state         <= ST_IDLE;
                            end
                        end
                    end
                    ST_STOP2: begin
                        tick_cnt <= tick_cnt + 1'b1;
                        if (at_bit) begin
                            xfer          <= 1'b1;
                            frame.data    <= shreg;
                            frame.frm_bad <= stop_bad || !line;
                            frame.par_bad <= cfg_q.par_en &&
                                parity_mismatch(shreg, par_bit, cfg_q.par_odd);
                            state         <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_errbuf.sv
module uart_rx_errbuf
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_all,
    input  logic              xfer,
    input  rx_frame_t         frame,
    input  logic              rd_lo,
    output logic [DATA_W-1:0] buf_data,
    output logic              buf_full,
    output rx_err_t           flags,
    output logic              irq
);
    logic overrun_now;

    // A read in the same cycle as the transfer frees the slot first
    assign overrun_now = buf_full && !rd_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_data <= '0;
            buf_full <= 1'b0;
            flags    <= '0;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (clr_all) begin
                buf_full <= 1'b0;
                flags    <= '0;
            end else if (xfer) begin
                buf_data  <= frame.data;
                buf_full  <= 1'b1;
                flags.frm <= frame.frm_bad || (flags.frm && !rd_lo);
                flags.par <= frame.par_bad || (flags.par && !rd_lo);
                if (overrun_now) flags.ovr <= 1'b1;
                else             irq       <= 1'b1;
            end else if (rd_lo) begin
                buf_full  <= 1'b0;
                flags.frm <= 1'b0;
                flags.par <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              os_tick,
    input  logic              rx_en,
    input  logic [2:0]        mode_sel,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop2,
    input  logic              rd_lo,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              err_ovr,
    output logic              err_frm,
    output logic              err_par,
    output logic              err_any,
    output logic              rx_irq
);
    logic      line_s;
    logic      active;
    logic      clr_all;
    logic      xfer_vld;
    rx_cfg_t   cfg;
    rx_frame_t frame;
    rx_err_t   flags;

    assign active  = rx_en && (mode_sel == MODE_ASYNC);
    assign clr_all = !rx_en || (mode_sel == MODE_OFF);
    assign cfg     = '{par_en: par_en, par_odd: par_odd, two_stop: stop2};

    uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (line_s)
    );

    uart_rx_deframer i_deframer (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .os_tick (os_tick),
        .line    (line_s),
        .cfg     (cfg),
        .xfer    (xfer_vld),
        .frame   (frame)
    );

    uart_rx_errbuf i_errbuf (
        .clk      (clk),
        .rst      (rst),
        .clr_all  (clr_all),
        .xfer     (xfer_vld),
        .frame    (frame),
        .rd_lo    (rd_lo),
        .buf_data (rx_data),
        .buf_full (rx_full),
        .flags    (flags),
        .irq      (rx_irq)
    );

    assign err_ovr = flags.ovr;
    assign err_frm = flags.frm;
    assign err_par = flags.par;
    assign err_any = flags.ovr || flags.frm || flags.par;
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk
    import uart_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic [2:0]        mode_sel,
    input logic              rd_lo,
    input logic              xfer_vld,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              err_ovr,
    input logic              err_frm,
    input logic              err_par,
    input logic              err_any,
    input logic              rx_irq
);
    // R10
    shutdown_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_en || mode_sel == MODE_OFF) |=> (!err_ovr && !err_frm && !err_par && !rx_full));

    // R10
    inactive_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_en || mode_sel != MODE_ASYNC) |=> !xfer_vld);

    // R7
    overrun_noirq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_ovr) |-> !rx_irq);

    // R3
    irq_with_full_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rx_full);

    // R3
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq);

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer_vld |=> $stable(rx_data));

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_lo && !xfer_vld) |=> (!rx_full && !err_frm && !err_par));

    // R8
    overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (err_ovr && rx_en && mode_sel != MODE_OFF) |=> err_ovr);

    // R9
    sum_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(err_any) |-> (!err_ovr && !err_frm && !err_par));
endmodule

bind uart_rx_core uart_rx_core_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_en    (rx_en),
    .mode_sel (mode_sel),
    .rd_lo    (rd_lo),
    .xfer_vld (xfer_vld),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .err_ovr  (err_ovr),
    .err_frm  (err_frm),
    .err_par  (err_par),
    .err_any  (err_any),
    .rx_irq   (rx_irq)
);

// File: tb/test_uart_rx_core.sv
module test_uart_rx_core;
    localparam int TDIV    = 3;
    localparam int BIT_CLK = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst;
    logic       rxd;
    logic       os_tick;
    logic       rx_en;
    logic [2:0] mode_sel;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
    logic       rd_lo;
    logic [7:0] rx_data;
    logic       rx_full;
    logic       err_ovr;
    logic       err_frm;
    logic       err_par;
    logic       err_any;
    logic       rx_irq;

    int vecs = 0;
    int errs = 0;
    int irq_cnt = 0;
    bit done = 0;

    logic [7:0] m_data;
    logic       m_full, m_ovr, m_frm, m_par;

    uart_rx_core i_uart_rx_core (
        .clk(clk), .rst(rst), .rxd(rxd), .os_tick(os_tick), .rx_en(rx_en),
        .mode_sel(mode_sel), .par_en(par_en), .par_odd(par_odd), .stop2(stop2),
        .rd_lo(rd_lo), .rx_data(rx_data), .rx_full(rx_full), .err_ovr(err_ovr),
        .err_frm(err_frm), .err_par(err_par), .err_any(err_any), .rx_irq(rx_irq)
    );

    always #5 clk = ~clk;

    initial begin
        os_tick = 1'b0;
        for (int t = 0; ; t++) begin
            @(negedge clk);
            os_tick = (t % TDIV == 0);
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (rx_irq) irq_cnt++;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    initial begin
        #(190000 * 10);
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        errs++;
        finish_run();
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic ones_odd(input logic [7:0] d);
        int n = 0;
        for (int i = 0; i < 8; i++) if (d[i]) n++;
        return (n % 2) == 1;
    endfunction

    task automatic check_state(input string req);
        chk(req, "rx_data", {24'd0, rx_data}, {24'd0, m_data});
        chk(req, "rx_full", {31'd0, rx_full}, {31'd0, m_full});
        chk(req, "err_ovr", {31'd0, err_ovr}, {31'd0, m_ovr});
        chk(req, "err_frm", {31'd0, err_frm}, {31'd0, m_frm});
        chk(req, "err_par", {31'd0, err_par}, {31'd0, m_par});
        chk("R9", "err_any", {31'd0, err_any}, {31'd0, m_ovr | m_frm | m_par});
    endtask

    task automatic line_bit(input logic v);
        rxd = v;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    // Sends one frame under the current config; the model is updated
    // only when the receiver is expected to accept the frame.
    task automatic send_frame(input logic [7:0] d, input logic flip_par,
                              input logic [1:0] bad_stop, input logic accepted,
                              input string req);
        logic pbit;
        logic fb;
        int   irq0;
        irq0 = irq_cnt;
        pbit = ones_odd(d) ^ par_odd ^ flip_par;
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(d[i]);
        if (par_en) line_bit(pbit);
        line_bit(!bad_stop[0]);
        if (stop2) line_bit(!bad_stop[1]);
        line_bit(1'b1);
        if (accepted) begin
            fb = bad_stop[0] || (stop2 && bad_stop[1]);
            if (m_full) m_ovr = 1'b1;
            chk(req, "irq count", irq_cnt - irq0, m_full ? 0 : 1);
            m_full = 1'b1;
            m_data = d;
            m_frm  = m_frm | fb;
            m_par  = m_par | (par_en & flip_par);
        end else begin
            chk(req, "irq count", irq_cnt - irq0, 0);
        end
        check_state(req);
    endtask

    task automatic read_lo(input string req);
        rd_lo = 1'b1;
        @(negedge clk);
        rd_lo = 1'b0;
        @(negedge clk);
        m_full = 1'b0;
        m_frm  = 1'b0;
        m_par  = 1'b0;
        check_state(req);
    endtask

    task automatic set_cfg(input logic pe, input logic po, input logic s2);
        par_en = pe; par_odd = po; stop2 = s2;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        rst = 1'b1; rxd = 1'b1; rx_en = 1'b1; mode_sel = 3'b101;
        par_en = 1'b0; par_odd = 1'b0; stop2 = 1'b0; rd_lo = 1'b0;
        m_data = '0; m_full = 0; m_ovr = 0; m_frm = 0; m_par = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (BIT_CLK) @(negedge clk);
        // R1 reset values
        check_state("R1");
        chk("R1", "rx_irq", {31'd0, rx_irq}, 32'd0);

        // R3 R4 even parity, good frame
        set_cfg(1, 0, 0);
        send_frame(8'hA5, 0, 2'b00, 1, "R3");
        read_lo("R8");
        send_frame(8'h01, 0, 2'b00, 1, "R3");
        read_lo("R8");
        // R4 odd parity with a corrupt parity bit
        set_cfg(1, 1, 0);
        send_frame(8'h3C, 1, 2'b00, 1, "R4");
        read_lo("R8");
        // R5 no parity bit
        set_cfg(0, 1, 0);
        send_frame(8'hC3, 0, 2'b00, 1, "R5");
        read_lo("R8");
        // R11 R6 two stop bits, second or first low
        set_cfg(0, 0, 1);
        send_frame(8'h5A, 0, 2'b10, 1, "R11");
        read_lo("R8");
        send_frame(8'h96, 0, 2'b01, 1, "R6");
        read_lo("R8");
        // R7 overrun: two frames with no read in between
        set_cfg(1, 0, 0);
        send_frame(8'h11, 0, 2'b00, 1, "R7");
        send_frame(8'h22, 0, 2'b00, 1, "R7");
        read_lo("R8");
        // R10 disabling clears the overrun
        rx_en = 1'b0;
        @(negedge clk); @(negedge clk);
        m_ovr = 0; m_full = 0; m_frm = 0; m_par = 0;
        check_state("R10");
        rx_en = 1'b1;
        // R10 mode 000 clears a framing flag
        send_frame(8'h77, 0, 2'b01, 1, "R6");
        mode_sel = 3'b000;
        @(negedge clk); @(negedge clk);
        m_full = 0; m_frm = 0;
        check_state("R10");
        // R10 other mode code: frame ignored
        mode_sel = 3'b011;
        send_frame(8'hEE, 0, 2'b00, 0, "R10");
        mode_sel = 3'b101;
        @(negedge clk);
        // R2 start glitch of 4 ticks
        begin
            int irq0;
            irq0 = irq_cnt;
            rxd = 1'b0;
            repeat (4 * TDIV) @(negedge clk);
            rxd = 1'b1;
            repeat (12 * BIT_CLK) @(negedge clk);
            chk("R2", "irq after glitch", irq_cnt - irq0, 0);
            check_state("R2");
        end

        // Random frames
        for (int k = 0; k < 80; k++) begin
            logic [7:0] d;
            logic fp;
            logic [1:0] bs;
            set_cfg($urandom % 2, $urandom % 2, $urandom % 2);
            d  = 8'($urandom);
            fp = ($urandom % 8) == 0;
            bs = (($urandom % 8) == 0) ? 2'($urandom % 3 + 1) : 2'b00;
            send_frame(d, fp, bs, 1, "R3");
            if (($urandom % 4) != 0) read_lo("R8");
        end

        finish_run();
    end
endmodule